// File: doc/BRIEF.md
# I/O Port Breakpoint Detector

This block watches port-mapped I/O accesses for debug breakpoints. Four breakpoint slots each supply an address, a 2-bit type code, a 2-bit length code and a local and a global enable. When an access is strobed, the block tests the byte span the access touches against the span of every slot that is both I/O-type and enabled. The test is inclusive at both ends. Slot addresses may be as wide as the full address register. Port sums are formed one bit wider than the operands, so the end of a span never wraps around to a low value.

On a hit, the block reports which slots matched. It copies the current debug status word through with its low four bits replaced by that hit mask. It also raises a trap request and captures the instruction pointer of the instruction after the access, so the debug exception resumes past the access (a trap, not a fault). The block also reports whether any I/O breakpoint is armed at all, so the surrounding pipeline can skip the check when none is. All outputs are registered.

Top module: `iobp_detect`

## Requirements
- R1: Only slots whose type code equals 2'b10 (I/O read/write) and whose local or global enable is set can hit. A slot of any other type, or with both enables low, never sets its hit bit.
- R2: An armed slot at address A with decoded length L hits when (port + size − 1) >= A and port <= A + L − 1. The test is inclusive at both ends, and size is 1, 2 or 4.
- R3: The slot length code decodes as 0 → 1 byte, 1 → 2 bytes, 2 → 8 bytes and 3 → 4 bytes.
- R4: One cycle after any clock edge, stat_out equals stat_in as it was sampled at that edge. When that edge saw a strobed access with a hit, bits [3:0] of stat_out are the hit mask instead; all other bits are still copied.
- R5: A strobed access with at least one hit gives trap_req high for exactly the next cycle, and resume_ip takes the access's acc_next_ip in that cycle. Otherwise resume_ip holds its value.
- R6: One cycle after the slot fields are sampled, armed is high exactly when at least one slot is I/O-type and enabled.
- R7: With acc_valid low, or with no slot hitting, the next cycle shows trap_req low, hit_mask zero and resume_ip unchanged.
- R8: Several slots can hit on one access. Bit i of hit_mask is set for every hitting slot i.
- R9: Sums are computed without wraparound. For example, port 16'hFFFF with size 4 reaches 32'h0001_0002, so it hits a slot at 32'h0001_0001.
- R10: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_port | input | 16 | First port number of the access |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_next_ip | input | 32 | Pointer to the instruction after the access |
| slot_addr | input | 128 | Slot addresses, slot i in bits [32i+31:32i] |
| slot_type | input | 8 | Slot type codes, slot i in bits [2i+1:2i] |
| slot_len | input | 8 | Slot length codes, slot i in bits [2i+1:2i] |
| slot_en_loc | input | 4 | Local enable per slot |
| slot_en_glb | input | 4 | Global enable per slot |
| stat_in | input | 32 | Current debug status word |
| hit_mask | output | 4 | Slots hit by the last strobed access |
| stat_out | output | 32 | Updated status word |
| trap_req | output | 1 | Debug trap request, one-cycle pulse |
| resume_ip | output | 32 | Instruction pointer at which to resume after the trap |
| armed | output | 1 | At least one I/O breakpoint is armed |

## Verification
Each output passes through one register stage, so the results of any input cycle are due at the following clock edge: hit_mask, trap_req, resume_ip, stat_out and armed. The driver applies each stimulus on a falling edge and queues the values the requirements predict. The monitor takes the head of the queue 1 ns after the next rising edge and compares all five outputs there. When the slot fields are changed, the driver drops acc_valid in that cycle and queues nothing. This way the held resume pointer never moves without a matching expected item.

// File: rtl/iobp_pkg.sv
package iobp_pkg;
  localparam logic [1:0] SLOT_TYPE_IO = 2'b10;
  localparam int LEN_CODE_W = 2;
  localparam int LEN_BYTES_W = 4;
endpackage

// File: rtl/iobp_len_dec.sv
module iobp_len_dec
  import iobp_pkg::*;
(
  input  logic [LEN_CODE_W-1:0]  code,
  output logic [LEN_BYTES_W-1:0] bytes
);
  always_comb begin
    unique case (code)
      2'd0: bytes = 4'd1;
      2'd1: bytes = 4'd2;
      2'd2: bytes = 4'd8;
      default: bytes = 4'd4;
    endcase
  end
endmodule

// File: rtl/iobp_slot_cmp.sv
module iobp_slot_cmp
  import iobp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic [PORT_W-1:0]     port,
  input  logic [SIZE_W-1:0]     size,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            typ,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  en_loc,
  input  logic                  en_glb,
  output logic                  armed_o,
  output logic                  hit_o
);
  localparam int BASE_W = (ADDR_W > PORT_W) ? ADDR_W : PORT_W;
  localparam int SUM_W  = BASE_W + 1;

  logic [LEN_BYTES_W-1:0] len_bytes;
  logic [SUM_W-1:0] first_p, last_p, slot_lo, slot_hi;

  iobp_len_dec len_dec_i (.code(len_code), .bytes(len_bytes));

  always_comb begin
    first_p = SUM_W'(port);
    last_p  = SUM_W'(port) + SUM_W'(size) - SUM_W'(1);
    slot_lo = SUM_W'(addr);
    slot_hi = SUM_W'(addr) + SUM_W'(len_bytes) - SUM_W'(1);
    armed_o = (typ == SLOT_TYPE_IO) && (en_loc || en_glb);
    hit_o   = armed_o && (last_p >= slot_lo) && (first_p <= slot_hi);
  end
endmodule

// File: rtl/iobp_status_merge.sv
module iobp_status_merge #(
  parameter int STAT_W = 32,
  parameter int NSLOT  = 4
) (
  input  logic [STAT_W-1:0] stat_in,
  input  logic [NSLOT-1:0]  hits,
  input  logic              take,
  output logic [STAT_W-1:0] stat_new
);
  always_comb begin
    stat_new = stat_in;
    if (take) stat_new[NSLOT-1:0] = hits;
  end
endmodule

// File: rtl/iobp_detect.sv
module iobp_detect
  import iobp_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int SIZE_W = 3,
  parameter int IP_W   = 32,
  parameter int STAT_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_valid,
  input  logic [PORT_W-1:0]            acc_port,
  input  logic [SIZE_W-1:0]            acc_size,
  input  logic [IP_W-1:0]              acc_next_ip,
  input  logic [NSLOT*ADDR_W-1:0]      slot_addr,
  input  logic [NSLOT*2-1:0]           slot_type,
  input  logic [NSLOT*LEN_CODE_W-1:0]  slot_len,
  input  logic [NSLOT-1:0]             slot_en_loc,
  input  logic [NSLOT-1:0]             slot_en_glb,
  input  logic [STAT_W-1:0]            stat_in,
  output logic [NSLOT-1:0]             hit_mask,
  output logic [STAT_W-1:0]            stat_out,
  output logic                         trap_req,
  output logic [IP_W-1:0]              resume_ip,
  output logic                         armed
);
  logic [NSLOT-1:0]  slot_hit, slot_armed;
  logic              take;
  logic [STAT_W-1:0] stat_new;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    iobp_slot_cmp #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .SIZE_W(SIZE_W)) cmp_i (
      .port    (acc_port),
      .size    (acc_size),
      .addr    (slot_addr[i*ADDR_W +: ADDR_W]),
      .typ     (slot_type[i*2 +: 2]),
      .len_code(slot_len[i*LEN_CODE_W +: LEN_CODE_W]),
      .en_loc  (slot_en_loc[i]),
      .en_glb  (slot_en_glb[i]),
      .armed_o (slot_armed[i]),
      .hit_o   (slot_hit[i])
    );
  end

  assign take = acc_valid && (|slot_hit);

  iobp_status_merge #(.STAT_W(STAT_W), .NSLOT(NSLOT)) merge_i (
    .stat_in (stat_in),
    .hits    (slot_hit),
    .take    (take),
    .stat_new(stat_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_mask  <= '0;
      stat_out  <= '0;
      trap_req  <= 1'b0;
      resume_ip <= '0;
      armed     <= 1'b0;
    end else begin
      hit_mask <= acc_valid ? slot_hit : '0;
      stat_out <= stat_new;
      trap_req <= take;
      armed    <= |slot_armed;
      if (take) resume_ip <= acc_next_ip;
    end
  end
endmodule

// File: rtl/iobp_detect_chk.sv
module iobp_detect_chk #(
  parameter int NSLOT  = 4,
  parameter int IP_W   = 32,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [IP_W-1:0]   acc_next_ip,
  input logic [STAT_W-1:0] stat_in,
  input logic [NSLOT-1:0]  hit_mask,
  input logic [STAT_W-1:0] stat_out,
  input logic              trap_req,
  input logic [IP_W-1:0]   resume_ip
);
  // R5: a trap only follows a strobed access
  a_r5_trap_after_valid: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(acc_valid));
  // R5: resume pointer carries the strobed next pointer
  a_r5_resume_ip: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> resume_ip == $past(acc_next_ip));
  // R4: upper status bits always pass through
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
    !rst |=> stat_out[STAT_W-1:NSLOT] == $past(stat_in[STAT_W-1:NSLOT]));
  // R4: on a trap the low status bits show the hit mask
  a_r4_low_is_mask: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> stat_out[NSLOT-1:0] == hit_mask);
  // R7: no strobe, no trap and no hits
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!trap_req && hit_mask == '0 && $stable(resume_ip)));
endmodule

bind iobp_detect iobp_detect_chk #(.NSLOT(NSLOT), .IP_W(IP_W), .STAT_W(STAT_W)) chk_i (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_next_ip(acc_next_ip),
  .stat_in(stat_in), .hit_mask(hit_mask), .stat_out(stat_out),
  .trap_req(trap_req), .resume_ip(resume_ip)
);

// File: tb/iobp_detect_tb_top.sv
`timescale 1ns/1ps
module iobp_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        acc_valid = 1'b0;
  logic [15:0] acc_port = '0;
  logic [2:0]  acc_size = 3'd1;
  logic [31:0] acc_next_ip = '0;
  logic [31:0] stat_in = '0;
  logic [31:0] s_addr [4];
  logic [1:0]  s_type [4];
  logic [1:0]  s_len  [4];
  logic [3:0]  s_le = '0, s_ge = '0;
  logic [127:0] slot_addr;
  logic [7:0]   slot_type, slot_len;
  logic [3:0]   hit_mask;
  logic [31:0]  stat_out, resume_ip;
  logic         trap_req, armed;

  for (genvar i = 0; i < 4; i++) begin : g_flat
    assign slot_addr[i*32 +: 32] = s_addr[i];
    assign slot_type[i*2 +: 2]   = s_type[i];
    assign slot_len[i*2 +: 2]    = s_len[i];
  end

  iobp_detect dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_port(acc_port),
    .acc_size(acc_size), .acc_next_ip(acc_next_ip), .slot_addr(slot_addr),
    .slot_type(slot_type), .slot_len(slot_len), .slot_en_loc(s_le),
    .slot_en_glb(s_ge), .stat_in(stat_in), .hit_mask(hit_mask),
    .stat_out(stat_out), .trap_req(trap_req), .resume_ip(resume_ip), .armed(armed)
  );

  typedef struct {
    logic [3:0]  mask;
    logic [31:0] stat;
    logic        trap;
    logic [31:0] ip;
    logic        arm;
    string       tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [31:0] exp_ip = '0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_hits(input longint port, input longint size);
    logic [3:0] h = '0;
    for (int i = 0; i < 4; i++) begin
      longint lb, a;
      lb = (s_len[i] == 2'd0) ? 1 : (s_len[i] == 2'd1) ? 2 : (s_len[i] == 2'd2) ? 8 : 4;
      a = longint'(s_addr[i]);
      if (s_type[i] == 2'b10 && (s_le[i] || s_ge[i]) &&
          (port + size - 1 >= a) && (port <= a + lb - 1)) h[i] = 1'b1;
    end
    return h;
  endfunction

  function automatic logic model_armed();
    logic a = 1'b0;
    for (int i = 0; i < 4; i++)
      if (s_type[i] == 2'b10 && (s_le[i] || s_ge[i])) a = 1'b1;
    return a;
  endfunction

  task automatic drive(input logic v, input logic [15:0] port, input logic [2:0] size,
                       input logic [31:0] nip, input logic [31:0] sin, input string tag);
    exp_t e;
    logic [3:0] h;
    @(negedge clk);
    acc_valid = v; acc_port = port; acc_size = size; acc_next_ip = nip; stat_in = sin;
    h = v ? model_hits(longint'(port), longint'(size)) : 4'd0;
    e.mask = h;
    e.trap = (h != 0);
    e.stat = (h != 0) ? {sin[31:4], h} : sin;
    if (h != 0) exp_ip = nip;
    e.ip  = exp_ip;
    e.arm = model_armed();
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_slot(input int i, input logic [31:0] a, input logic [1:0] t,
                          input logic [1:0] l, input logic le, input logic ge);
    @(negedge clk);
    acc_valid = 1'b0;
    s_addr[i] = a; s_type[i] = t; s_len[i] = l; s_le[i] = le; s_ge[i] = ge;
  endtask

  // monitor: compares results one edge after each stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " hit_mask"}, {28'd0, hit_mask}, {28'd0, e.mask});
        chk({e.tag, "/R4 stat_out"}, stat_out, e.stat);
        chk({e.tag, "/R5 trap_req"}, {31'd0, trap_req}, {31'd0, e.trap});
        chk({e.tag, "/R5 resume_ip"}, resume_ip, e.ip);
        chk({e.tag, "/R6 armed"}, {31'd0, armed}, {31'd0, e.arm});
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      s_addr[i] = '0; s_type[i] = 2'b00; s_len[i] = 2'b00;
    end
    stat_in = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 hit_mask", {28'd0, hit_mask}, 32'd0);
    chk("R10 stat_out", stat_out, 32'd0);
    chk("R10 trap_req", {31'd0, trap_req}, 32'd0);
    chk("R10 resume_ip", resume_ip, 32'd0);
    chk("R10 armed", {31'd0, armed}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    drive(1, 16'h0060, 3'd1, 32'h1000, 32'hFFFF_0FF0, "R7 all disabled");
    set_slot(0, 32'h60, 2'b10, 2'd0, 1, 0);
    drive(1, 16'h0060, 3'd1, 32'h1004, 32'hFFFF_0FF0, "R2 exact hit");
    drive(1, 16'h005F, 3'd1, 32'h1008, 32'h1234_5670, "R2 below miss");
    drive(1, 16'h005F, 3'd2, 32'h100C, 32'h1234_567F, "R2 last byte hit");
    drive(1, 16'h0061, 3'd1, 32'h1010, 32'h0000_000A, "R2 above miss");
    drive(0, 16'h0060, 3'd1, 32'h1014, 32'hAAAA_5555, "R7 strobe low");
    set_slot(1, 32'h70, 2'b00, 2'd0, 1, 1);
    drive(1, 16'h0070, 3'd1, 32'h1018, 32'h0, "R1 non-io type");
    set_slot(1, 32'h70, 2'b10, 2'd0, 0, 0);
    drive(1, 16'h0070, 3'd1, 32'h101C, 32'h0, "R1 io disabled");
    set_slot(0, 32'h60, 2'b10, 2'd0, 0, 0);
    drive(1, 16'h0060, 3'd1, 32'h1020, 32'h0, "R6 disarmed");
    set_slot(2, 32'h100, 2'b10, 2'd2, 1, 0);
    drive(1, 16'h0107, 3'd1, 32'h1024, 32'h5, "R3 len8 end hit");
    drive(1, 16'h0108, 3'd1, 32'h1028, 32'h5, "R3 len8 past miss");
    set_slot(2, 32'h100, 2'b10, 2'd3, 1, 0);
    drive(1, 16'h0103, 3'd1, 32'h102C, 32'h5, "R3 len4 end hit");
    drive(1, 16'h0104, 3'd1, 32'h1030, 32'h5, "R3 len4 past miss");
    set_slot(2, 32'h100, 2'b10, 2'd1, 1, 0);
    drive(1, 16'h0101, 3'd1, 32'h1034, 32'h5, "R3 len2 end hit");
    drive(1, 16'h0102, 3'd1, 32'h1038, 32'h5, "R3 len2 past miss");
    set_slot(0, 32'h102, 2'b10, 2'd0, 1, 0);
    set_slot(2, 32'h100, 2'b10, 2'd0, 1, 0);
    set_slot(3, 32'h103, 2'b10, 2'd0, 0, 1);
    drive(1, 16'h0100, 3'd4, 32'h103C, 32'hCAFE_F00D, "R8 multi hit");
    drive(1, 16'h0101, 3'd2, 32'h1040, 32'hCAFE_F00D, "R8 partial hit");
    set_slot(1, 32'h0001_0001, 2'b10, 2'd0, 1, 0);
    drive(1, 16'hFFFF, 3'd4, 32'h1044, 32'h8000_0000, "R9 no wrap hit");
    drive(1, 16'hFFFF, 3'd2, 32'h1048, 32'h8000_0000, "R9 short miss");
    drive(0, 16'h0, 3'd1, 32'h104C, 32'h0, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule